// File: doc/BRIEF.md
# Three-Digit Decimal Event Counter with Ring-Coded Digits

This block counts enabled clock cycles from 000 to 999 and wraps around. Each decimal digit is stored as a five-bit shifting-ones ring instead of a binary nibble. Every ring changes by one bit per step, and the ring is converted to a four-bit BCD code at the outputs. All digits share one clock. The count enable advances the lowest digit. A digit's terminal-count signal is the enable of the digit above it, so it never drives a clock.

Each digit above the lowest has a flag for leading-zero suppression, and a blanking-enable input switches the flags on or off. A registered carry-out marks the wrap from 999 to 000. A synchronous clear sets the count back to zero. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `jdc_counter3`

## Requirements
- R1: While `rst_n` is low, and after it is released with no enable, `bcd_o` reads 000, `carry_o` is 0, and the blanking flags follow R7.
- R2: Each rising edge with `cnt_en`=1 and `clr`=0 raises the count by one. `bcd_o[3:0]` holds the units digit, `[7:4]` the tens digit and `[11:8]` the hundreds digit, each as plain BCD in the range 0 to 9.
- R3: A digit advances on the same edge on which every digit below it wraps from 9 to 0, so 009 is followed by 010 and 099 by 100.
- R4: An edge with `cnt_en`=0 and `clr`=0 leaves every digit unchanged, and `carry_o` reads 0 after that edge.
- R5: An enabled edge at 999 gives 000. `carry_o` is 1 for exactly the one cycle after that edge and is 0 at all other times.
- R6: An edge with `clr`=1 sets the count to 000 and `carry_o` to 0, whatever `cnt_en` is.
- R7: With `blank_en`=1, `blank_o[i]` for i≥1 is 1 exactly when digit i and every more significant digit are 0. `blank_o[0]` is always 0.
- R8: With `blank_en`=0, every bit of `blank_o` is 0.
- R9: A digit ring holding a pattern outside the ten valid ring states reads as BCD 0. It returns to the zero state on its next enabled edge, then counts on normally (ring states 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 stand for 0 to 9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all digits |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear to 000, has priority over counting |
| cnt_en | input | 1 | Count enable for the units digit |
| blank_en | input | 1 | Enables the leading-zero blanking flags |
| bcd_o | output | 12 | Three BCD digits, units in the low nibble |
| blank_o | output | 3 | Per-digit blank flag, bit i for digit i |
| carry_o | output | 1 | One-cycle pulse after the wrap from 999 to 000 |

## Verification
No sequence at the ports can put a ring into an invalid pattern, so the self-correction path is the hardest case to reach. The bench first holds the counter idle. It then overrides the units ring with an invalid pattern between clock edges and releases the override. After that it applies two enabled edges and expects to read 0 and then 1. The rest of the run covers all three carry boundaries and the wrap: more than a thousand enabled steps are compared against an integer model, with idle gaps placed throughout. Two clears are included, one of them on the very edge that would wrap from 999.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  localparam int RING_W  = 5;
  localparam int BCD_W   = 4;

  typedef logic [RING_W-1:0] ring_t;
  typedef logic [BCD_W-1:0]  bcd_t;

  localparam ring_t RING_ZERO = '0;
  localparam ring_t RING_NINE = ring_t'(1) << (RING_W - 1);

  // A valid shifting-ones pattern has at most one place where
  // neighbouring bits differ.
  function automatic logic ring_legal(input ring_t r);
    int edges;
    edges = 0;
    for (int i = 0; i < RING_W - 1; i++) begin
      if (r[i] != r[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

  function automatic bcd_t ring_to_bcd(input ring_t r);
    int ones;
    bcd_t val;
    ones = $countones(r);
    if (!ring_legal(r))      val = '0;
    else if (r[RING_W-1])    val = bcd_t'(2 * RING_W - ones);
    else                     val = bcd_t'(ones);
    return val;
  endfunction

  function automatic ring_t ring_advance(input ring_t r);
    ring_t nxt;
    if (ring_legal(r)) nxt = {r[RING_W-2:0], ~r[RING_W-1]};
    else               nxt = RING_ZERO;
    return nxt;
  endfunction

endpackage

// File: rtl/jdc_rst_sync.sv
module jdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/jdc_digit.sv
module jdc_digit
  import jdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output bcd_t bcd,
  output logic tc
);

  ring_t ring_q;
  ring_t ring_d;

  always_comb begin
    ring_d = ring_q;
    if (clr)     ring_d = RING_ZERO;
    else if (en) ring_d = ring_advance(ring_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= RING_ZERO;
    else        ring_q <= ring_d;
  end

  assign bcd = ring_to_bcd(ring_q);
  // Terminal count: digit nine and this stage is being stepped.
  assign tc  = en && (ring_q == RING_NINE);

endmodule

// File: rtl/jdc_blank.sv
module jdc_blank
  import jdc_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                        blank_en,
  input  logic [NUM_DIGITS*BCD_W-1:0] bcd_flat,
  output logic [NUM_DIGITS-1:0]       blank
);

  logic [NUM_DIGITS:0] zero_from;

  assign zero_from[NUM_DIGITS] = 1'b1;

  for (genvar i = NUM_DIGITS - 1; i >= 0; i--) begin : g_zero
    assign zero_from[i] = zero_from[i+1] &&
                          (bcd_flat[i*BCD_W +: BCD_W] == '0);
  end

  assign blank[0] = 1'b0;

  for (genvar i = 1; i < NUM_DIGITS; i++) begin : g_flag
    assign blank[i] = blank_en && zero_from[i];
  end

endmodule

// File: rtl/jdc_counter3.sv
module jdc_counter3
  import jdc_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        cnt_en,
  input  logic                        blank_en,
  output logic [NUM_DIGITS*BCD_W-1:0] bcd_o,
  output logic [NUM_DIGITS-1:0]       blank_o,
  output logic                        carry_o
);

  logic                  rst_core_n;
  logic [NUM_DIGITS:0]   stage_en;
  logic [NUM_DIGITS-1:0] stage_tc;
  logic                  carry_d;
  logic                  carry_q;

  jdc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign stage_en[0] = cnt_en;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    jdc_digit u_digit (
      .clk (clk),
      .rst_n (rst_core_n),
      .clr (clr),
      .en  (stage_en[i]),
      .bcd (bcd_o[i*BCD_W +: BCD_W]),
      .tc  (stage_tc[i])
    );
    assign stage_en[i+1] = stage_tc[i];
  end

  jdc_blank #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
    .blank_en (blank_en),
    .bcd_flat (bcd_o),
    .blank    (blank_o)
  );

  always_comb begin
    carry_d = stage_en[NUM_DIGITS] && !clr;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) carry_q <= 1'b0;
    else             carry_q <= carry_d;
  end

  assign carry_o = carry_q;

endmodule

// File: rtl/jdc_counter3_chk.sv
module jdc_counter3_chk
  import jdc_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clr,
  input logic                        cnt_en,
  input logic                        blank_en,
  input logic [NUM_DIGITS*BCD_W-1:0] bcd_o,
  input logic [NUM_DIGITS-1:0]       blank_o,
  input logic                        carry_o
);

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(bcd_o));

  a_r4_no_carry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !carry_o);

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bcd_o == '0 && !carry_o));

  a_r5_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);

  a_r5_carry_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (bcd_o == '0));

  a_r7_lsd_shown: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_o[0]);

  a_r8_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_en |-> (blank_o == '0));

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_range
    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_o[i*BCD_W +: BCD_W] <= bcd_t'(9));
  end

endmodule

bind jdc_counter3 jdc_counter3_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (.*);

// File: tb/jdc_counter3_tb_top.sv
`timescale 1ns/1ps
module jdc_counter3_tb_top;

  typedef struct {
    logic [11:0] bcd;
    logic        carry;
    logic [2:0]  blank;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        cnt_en;
  logic        blank_en;
  logic [11:0] bcd_o;
  logic [2:0]  blank_o;
  logic        carry_o;

  int    n_checks;
  int    n_fail;
  int    ref_cnt;
  logic  ref_carry;
  logic  done;
  item_t exp_q[$];

  jdc_counter3 #(.NUM_DIGITS(3)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cnt_en   (cnt_en),
    .blank_en (blank_en),
    .bcd_o    (bcd_o),
    .blank_o  (blank_o),
    .carry_o  (carry_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [2:0] exp_blank(input int v, input logic ben);
    return ben ? {v < 100, v < 10, 1'b0} : 3'b000;
  endfunction

  task automatic compare(input item_t e);
    n_checks++;
    if (bcd_o !== e.bcd || carry_o !== e.carry || blank_o !== e.blank) begin
      n_fail++;
      $display("FAIL %s: actual bcd=%h carry=%b blank=%b expected bcd=%h carry=%b blank=%b",
               e.tag, bcd_o, carry_o, blank_o, e.bcd, e.carry, e.blank);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic step(input logic en, input logic c, input logic ben,
                      input logic skip, input string tag);
    item_t it;
    int    prev;
    string t;
    @(negedge clk);
    cnt_en   = en;
    clr      = c;
    blank_en = ben;
    @(posedge clk);
    prev = ref_cnt;
    if (c) begin
      ref_cnt   = 0;
      ref_carry = 1'b0;
    end else if (en && !skip) begin
      ref_carry = (ref_cnt == 999);
      ref_cnt   = (ref_cnt + 1) % 1000;
    end else begin
      ref_carry = 1'b0;
    end
    t = tag;
    if (t == "") begin
      if (!en)                         t = "R4";
      else if (prev == 999)            t = "R5";
      else if (prev % 10 == 9)         t = "R3";
      else if (ben && (ref_cnt == 0 || ref_cnt == 7 ||
                       ref_cnt == 40 || ref_cnt == 305)) t = "R7";
      else                             t = "R2";
    end
    it.bcd   = to_bcd(ref_cnt);
    it.carry = ref_carry;
    it.blank = exp_blank(ref_cnt, ben);
    it.tag   = t;
    exp_q.push_back(it);
  endtask

  // Monitor: compare queued expectations shortly after each edge.
  initial begin
    item_t e;
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        compare(e);
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    item_t r;
    n_checks  = 0;
    n_fail    = 0;
    ref_cnt   = 0;
    ref_carry = 1'b0;
    rst_n     = 1'b0;
    clr       = 1'b0;
    cnt_en    = 1'b0;
    blank_en  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    r.bcd = 12'h000; r.carry = 1'b0; r.blank = 3'b110; r.tag = "R1";
    compare(r);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b1, 1'b0, "R1");

    // Long enabled run with idle gaps, crossing every boundary and the wrap.
    for (int i = 0; i < 1100; i++) begin
      step((i % 97) != 50, 1'b0, 1'b1, 1'b0, "");
    end

    repeat (5) step(1'b1, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6");

    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 990; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6");

    // Invalid ring pattern in the units digit while idle.
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    @(negedge clk);
    force dut_i.g_digit[0].u_digit.ring_q = 5'b01010;
    #0.5;
    release dut_i.g_digit[0].u_digit.ring_q;
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, 1'b1, "R9");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R9");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule